// File: doc/BRIEF.md
# GPIO Controller with Pin Interrupts

This block is a register-mapped general-purpose I/O controller for up to 31 pins on a simple 32-bit register bus. Software sets each pin's direction and changes the output latch through two registers. One register sets bits and the other clears them, so no read-modify-write is needed. Every input passes through a two-flop synchronizer. The synchronized values can be read back, and they feed the interrupt logic.

Each pin can raise an interrupt on a level or on an edge. A polarity bit selects high/rising or low/falling. A pin records events in its pending bit only while its enable bit is set. The single CPU interrupt line is asserted when a pending bit has both its enable bit and its mask bit set. The hardware does not detect both edges. Software can emulate them by writing polarity as the inverse of the current input after each event, so a polarity rewrite must never create an event on its own. A build parameter swaps the meaning of the direction register for systems that treat a 1 as "input".

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset all pins are inputs (`pin_oe` all 0), `pin_out` is 0, `irq` is 0, and every configuration and pending register reads 0. In inverted-direction mode the direction register reads all ones over the configured pins.
- R2: Direction register at byte offset 0x00. With `DIR_INVERT`=0 a 1 makes the pin drive (`pin_oe`=1). With `DIR_INVERT`=1 a 1 makes the pin an input. The change shows at `pin_oe` one cycle after the write.
- R3: A write to offset 0x0C sets every output bit whose data bit is 1. A write to offset 0x10 clears every output bit whose data bit is 1. Zero bits leave the latch unchanged, and both offsets read back the output latch.
- R4: Offset 0x04 reads the pin states after a two-flop synchronizer. Read data is registered and is valid in the cycle after the read strobe. A pin change made just before a read is therefore not yet visible to that read, and it is visible to the next read.
- R5: With type bit (offset 0x18) 0 the pin is edge-sensitive. Polarity bit (offset 0x1C) 1 selects the rising edge and 0 selects the falling edge. The pending bit sets only while the enable bit (offset 0x14) is 1.
- R6: With type bit 1 the pin is level-sensitive. Its pending bit equals enable AND (pin == polarity), so it drops when the level goes away.
- R7: Writing 1 to a pending bit (offset 0x20) clears a latched edge event. Zero bits leave pending bits unchanged.
- R8: `irq` is a register holding the OR over pins of pending AND enable AND mask (mask at offset 0x24). It rises four clock edges after a qualifying pin change. Clearing the mask bit lowers `irq` but keeps the pending bit.
- R9: Rewriting the polarity of an edge-sensitive pin while its input is steady never sets its pending bit. Rewriting polarity to the inverse of the current input does catch the next change, which gives both-edge emulation.
- R10: Bits at and above `NUM_PINS` read as zero in every register, and writes to them have no effect. An address with no register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after `bus_rd` |
| pin_in | input | NUM_PINS | Asynchronous pin inputs |
| pin_out | output | NUM_PINS | Output latch |
| pin_oe | output | NUM_PINS | Per-pin output enable |
| irq | output | 1 | Registered combined interrupt |

## Verification
The checker checks on every cycle the timing of `irq` against the qualified pending bits of the previous cycle. It also checks that a newly latched edge event always had its enable bit set, that set and clear writes reach the output latch, that a direction write maps to `pin_oe` in the selected mode, and that no read data appears above the pin count. The bench scenarios are needed for the rest. These cover the synchronizer latency seen through the input register, the exact edge at which `irq` rises, the fact that a polarity rewrite on a steady pin produces no event, the both-edge emulation sequence, and level bits dropping with the level. Random pin patterns under random configurations are checked against a bench model of edge and level pending bits.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int BUS_W = 32;

    localparam logic [7:0] OFS_DIR  = 8'h00;
    localparam logic [7:0] OFS_IN   = 8'h04;
    localparam logic [7:0] OFS_SET  = 8'h0C;
    localparam logic [7:0] OFS_CLR  = 8'h10;
    localparam logic [7:0] OFS_EN   = 8'h14;
    localparam logic [7:0] OFS_TYPE = 8'h18;
    localparam logic [7:0] OFS_POL  = 8'h1C;
    localparam logic [7:0] OFS_PEND = 8'h20;
    localparam logic [7:0] OFS_MASK = 8'h24;

    typedef enum logic [3:0] {
        SEL_DIR, SEL_IN, SEL_SET, SEL_CLR, SEL_EN,
        SEL_TYPE, SEL_POL, SEL_PEND, SEL_MASK, SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic [BUS_W-1:0] dir;
        logic [BUS_W-1:0] out;
        logic [BUS_W-1:0] en;
        logic [BUS_W-1:0] trig_level;
        logic [BUS_W-1:0] pol;
        logic [BUS_W-1:0] mask;
    } gpio_cfg_t;

    function automatic reg_sel_e decode_sel(input logic [7:0] a);
        case (a)
            OFS_DIR:  return SEL_DIR;
            OFS_IN:   return SEL_IN;
            OFS_SET:  return SEL_SET;
            OFS_CLR:  return SEL_CLR;
            OFS_EN:   return SEL_EN;
            OFS_TYPE: return SEL_TYPE;
            OFS_POL:  return SEL_POL;
            OFS_PEND: return SEL_PEND;
            OFS_MASK: return SEL_MASK;
            default:  return SEL_NONE;
        endcase
    endfunction

    function automatic logic [BUS_W-1:0] pin_mask(input int n);
        logic [BUS_W-1:0] m;
        m = '0;
        for (int i = 0; i < BUS_W; i++) begin
            if (i < n) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int NUM_PINS = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] cur,
    output logic [NUM_PINS-1:0] prev
);
    logic [NUM_PINS-1:0] meta_q;
    logic [NUM_PINS-1:0] sync_q;
    logic [NUM_PINS-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign cur  = sync_q;
    assign prev = prev_q;
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS   = 16,
    parameter bit DIR_INVERT = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  reg_sel_e         sel,
    input  logic [BUS_W-1:0] wdata,
    output gpio_cfg_t        cfg,
    output logic [BUS_W-1:0] w1c
);
    localparam logic [BUS_W-1:0] PMASK   = pin_mask(NUM_PINS);
    localparam logic [BUS_W-1:0] DIR_RST = DIR_INVERT ? PMASK : '0;

    gpio_cfg_t        cfg_q;
    logic [BUS_W-1:0] wd;

    assign wd = wdata & PMASK;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q            <= '0;
            cfg_q.dir        <= DIR_RST;
        end else if (wr) begin
            case (sel)
                SEL_DIR:  cfg_q.dir        <= wd;
                SEL_SET:  cfg_q.out        <= cfg_q.out | wd;
                SEL_CLR:  cfg_q.out        <= cfg_q.out & ~wd;
                SEL_EN:   cfg_q.en         <= wd;
                SEL_TYPE: cfg_q.trig_level <= wd;
                SEL_POL:  cfg_q.pol        <= wd;
                SEL_MASK: cfg_q.mask       <= wd;
                default:  ;
            endcase
        end
    end

    assign cfg = cfg_q;
    assign w1c = (wr && sel == SEL_PEND) ? wd : '0;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] cur,
    input  logic [NUM_PINS-1:0] prev,
    input  gpio_cfg_t           cfg,
    input  logic [BUS_W-1:0]    w1c,
    output logic [BUS_W-1:0]    pend,
    output logic                irq
);
    logic [BUS_W-1:0] pend_q;

    for (genvar i = 0; i < BUS_W; i++) begin : g_pin
        if (i < NUM_PINS) begin : g_live
            logic rise, fall, hit, lvl;
            assign rise = cur[i] & ~prev[i];
            assign fall = ~cur[i] & prev[i];
            assign hit  = cfg.en[i] & (cfg.pol[i] ? rise : fall);
            assign lvl  = cfg.en[i] & (cur[i] == cfg.pol[i]);
            always_ff @(posedge clk) begin
                if (rst)                    pend_q[i] <= 1'b0;
                else if (cfg.trig_level[i]) pend_q[i] <= lvl;
                else                        pend_q[i] <= (pend_q[i] & ~w1c[i]) | hit;
            end
        end else begin : g_tie
            assign pend_q[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |(pend_q & cfg.en & cfg.mask);
    end

    assign pend = pend_q;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS   = 16,
    parameter bit DIR_INVERT = 1'b0,
    parameter int ADDR_W     = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [31:0]         bus_wdata,
    input  logic                bus_rd,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);
    if (NUM_PINS < 1 || NUM_PINS > 31) begin : g_bad_pins
        $error("NUM_PINS must be 1..31");
    end
    if (ADDR_W < 6 || ADDR_W > 8) begin : g_bad_addr
        $error("ADDR_W must be 6..8");
    end

    reg_sel_e            sel;
    gpio_cfg_t           cfg;
    logic [BUS_W-1:0]    w1c;
    logic [BUS_W-1:0]    pend_vec;
    logic [NUM_PINS-1:0] cur, prev;
    logic [BUS_W-1:0]    in_vec;
    logic [BUS_W-1:0]    rd_mux;
    logic [BUS_W-1:0]    rdata_q;

    assign sel    = decode_sel(8'(bus_addr));
    assign in_vec = BUS_W'(cur);

    gpio_in_sync #(.NUM_PINS(NUM_PINS)) u_sync (
        .clk(clk), .rst(rst), .pin_in(pin_in), .cur(cur), .prev(prev)
    );

    gpio_cfg_regs #(.NUM_PINS(NUM_PINS), .DIR_INVERT(DIR_INVERT)) u_regs (
        .clk(clk), .rst(rst), .wr(bus_wr), .sel(sel), .wdata(bus_wdata),
        .cfg(cfg), .w1c(w1c)
    );

    gpio_irq_detect #(.NUM_PINS(NUM_PINS)) u_detect (
        .clk(clk), .rst(rst), .cur(cur), .prev(prev), .cfg(cfg),
        .w1c(w1c), .pend(pend_vec), .irq(irq)
    );

    always_comb begin
        case (sel)
            SEL_DIR:          rd_mux = cfg.dir;
            SEL_IN:           rd_mux = in_vec;
            SEL_SET, SEL_CLR: rd_mux = cfg.out;
            SEL_EN:           rd_mux = cfg.en;
            SEL_TYPE:         rd_mux = cfg.trig_level;
            SEL_POL:          rd_mux = cfg.pol;
            SEL_PEND:         rd_mux = pend_vec;
            SEL_MASK:         rd_mux = cfg.mask;
            default:          rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_mux;
        else             rdata_q <= '0;
    end

    assign bus_rdata = rdata_q;
    assign pin_out   = cfg.out[NUM_PINS-1:0];
    assign pin_oe    = DIR_INVERT ? ~cfg.dir[NUM_PINS-1:0] : cfg.dir[NUM_PINS-1:0];
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS   = 16,
    parameter bit DIR_INVERT = 1'b0,
    parameter int ADDR_W     = 8
) (
    input logic                clk,
    input logic                rst,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_wr,
    input logic [31:0]         bus_wdata,
    input logic [31:0]         bus_rdata,
    input logic [NUM_PINS-1:0] pin_out,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic                irq,
    input logic [BUS_W-1:0]    pend,
    input logic [BUS_W-1:0]    en,
    input logic [BUS_W-1:0]    msk,
    input logic [BUS_W-1:0]    trig
);
    localparam logic [BUS_W-1:0] PMASK = pin_mask(NUM_PINS);

    AST_IRQ_TIMING: assert property (@(posedge clk) disable iff (rst)
        irq == $past(|(pend & en & msk))); // R8

    AST_EDGE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        (pend & ~$past(pend) & ~$past(trig) & ~$past(en)) == '0); // R5

    AST_SET_REACHES_PIN: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(OFS_SET)) |=>
        ((pin_out & $past(bus_wdata[NUM_PINS-1:0])) == $past(bus_wdata[NUM_PINS-1:0]))); // R3

    AST_CLR_REACHES_PIN: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(OFS_CLR)) |=>
        ((pin_out & $past(bus_wdata[NUM_PINS-1:0])) == '0)); // R3

    AST_DIR_MODE: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(OFS_DIR)) |=>
        (pin_oe == (DIR_INVERT ? ~$past(bus_wdata[NUM_PINS-1:0])
                               : $past(bus_wdata[NUM_PINS-1:0])))); // R2

    AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata & ~PMASK) == '0); // R10
endmodule

bind gpio_irq_ctrl gpio_irq_chk #(
    .NUM_PINS(NUM_PINS), .DIR_INVERT(DIR_INVERT), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq), .pend(pend_vec), .en(cfg.en),
    .msk(cfg.mask), .trig(cfg.trig_level)
);

// File: tb/test_gpio_irq_ctrl.sv
module test_gpio_irq_ctrl;
    localparam int N = 16;
    localparam logic [31:0] PM = 32'h0000_FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata, rdata_inv;
    logic [N-1:0] pin_in = '0;
    logic [N-1:0] pin_out, pin_oe, pin_out_inv, pin_oe_inv;
    logic        irq, irq_inv;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    gpio_irq_ctrl #(.NUM_PINS(N), .DIR_INVERT(1'b0)) i_gpio_irq_ctrl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    gpio_irq_ctrl #(.NUM_PINS(N), .DIR_INVERT(1'b1)) i_gpio_irq_ctrl_inv (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(rdata_inv),
        .pin_in(pin_in), .pin_out(pin_out_inv), .pin_oe(pin_oe_inv), .irq(irq_inv)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic [31:0] d_inv);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        d = bus_rdata; d_inv = rdata_inv;
        bus_rd = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] edge_hits(input logic [31:0] o, input logic [31:0] n,
                                              input logic [31:0] e, input logic [31:0] t,
                                              input logic [31:0] p);
        return PM & e & ~t & ((p & n & ~o) | (~p & ~n & o));
    endfunction

    function automatic logic [31:0] level_bits(input logic [31:0] pins, input logic [31:0] e,
                                               input logic [31:0] t, input logic [31:0] p);
        return PM & e & t & ~(pins ^ p);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d, di, en_r, ty_r, po_r, mk_r, exp, oldp, newp;
        void'($urandom(32'h1234_5678));
        settle(3);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 pin_oe", 32'(pin_oe), 0);
        check("R1 pin_out", 32'(pin_out), 0);
        check("R1 irq", 32'(irq), 0);
        check("R1 inv pin_oe", 32'(pin_oe_inv), 0);
        rd(8'h00, d, di);
        check("R1 dir", d, 0);
        check("R1 inv dir", di, PM);
        rd(8'h20, d, di);
        check("R1 pend", d, 0);
        rd(8'h14, d, di);
        check("R1 en", d, 0);

        // R2 direction, both modes
        wr(8'h00, 32'h0000_00F0);
        check("R2 normal oe", 32'(pin_oe), 32'h00F0);
        check("R2 inverted oe", 32'(pin_oe_inv), 32'hFF0F);

        // R3 set/clear with zero bits untouched
        wr(8'h0C, 32'h0000_1234);
        wr(8'h0C, 32'h0000_8001);
        check("R3 set", 32'(pin_out), 32'h9235);
        wr(8'h10, 32'h0000_0204);
        check("R3 clear", 32'(pin_out), 32'h9031);
        rd(8'h0C, d, di);
        check("R3 set readback", d, 32'h9031);
        rd(8'h10, d, di);
        check("R3 clear readback", d, 32'h9031);

        // R10 upper bits and unmapped address
        wr(8'h14, 32'hFFFF_0000);
        rd(8'h14, d, di);
        check("R10 upper en ignored", d, 0);
        wr(8'h0C, 32'hFFFF_0000);
        check("R10 upper set ignored", 32'(pin_out), 32'h9031);
        rd(8'h08, d, di);
        check("R10 unmapped", d, 0);

        // R4 synchronizer latency seen through input register
        pin_in = 16'hA5C3;
        rd(8'h04, d, di);
        check("R4 early read old", d, 0);
        rd(8'h04, d, di);
        check("R4 synced read", d, 32'hA5C3);

        // R5/R8 rising edge on pin 0 and irq latency
        pin_in = 16'h0000;
        settle(4);
        wr(8'h18, 32'h0);
        wr(8'h1C, 32'h1);
        wr(8'h14, 32'h1);
        wr(8'h24, 32'h1);
        wr(8'h20, PM);
        pin_in = 16'h0001;
        settle(3);
        check("R8 irq not yet", 32'(irq), 0);
        settle(1);
        check("R8 irq after four edges", 32'(irq), 1);
        rd(8'h20, d, di);
        check("R5 rising pend", d, 1);

        // R8 mask lowers irq, pending kept
        wr(8'h24, 32'h0);
        settle(1);
        check("R8 masked irq", 32'(irq), 0);
        rd(8'h20, d, di);
        check("R8 pend kept", d, 1);
        wr(8'h24, 32'h1);

        // R7 write-one clear, zero bits no effect
        wr(8'h20, 32'h2);
        rd(8'h20, d, di);
        check("R7 zero bit no clear", d, 1);
        wr(8'h20, 32'h1);
        rd(8'h20, d, di);
        check("R7 w1c", d, 0);
        settle(1);
        check("R7 irq gone", 32'(irq), 0);

        // R5 falling edge ignored while disabled, caught when enabled
        wr(8'h14, 32'h0);
        wr(8'h1C, 32'h0);
        pin_in = 16'h0000;
        settle(5);
        rd(8'h20, d, di);
        check("R5 disabled no pend", d, 0);
        wr(8'h14, 32'h1);
        pin_in = 16'h0001;
        settle(5);
        rd(8'h20, d, di);
        check("R5 wrong edge no pend", d, 0);
        pin_in = 16'h0000;
        settle(5);
        rd(8'h20, d, di);
        check("R5 falling pend", d, 1);
        wr(8'h20, PM);

        // R9 polarity rewrite on steady pin and both-edge emulation
        pin_in = 16'h0001;
        settle(5);
        wr(8'h20, PM);
        wr(8'h1C, 32'h1);
        wr(8'h1C, 32'h0);
        wr(8'h1C, 32'h1);
        wr(8'h1C, 32'h0);
        settle(3);
        rd(8'h20, d, di);
        check("R9 polarity rewrite no pend", d, 0);
        pin_in = 16'h0000;
        settle(5);
        rd(8'h20, d, di);
        check("R9 emulated falling", d, 1);
        wr(8'h1C, 32'h1);
        wr(8'h20, 32'h1);
        pin_in = 16'h0001;
        settle(5);
        rd(8'h20, d, di);
        check("R9 emulated rising", d, 1);

        // R6 level follows the pin
        wr(8'h18, 32'h4);
        wr(8'h1C, 32'h4);
        wr(8'h14, 32'h4);
        wr(8'h20, PM);
        pin_in = 16'h0004;
        settle(4);
        rd(8'h20, d, di);
        check("R6 level high pend", d, 4);
        wr(8'h20, 32'h4);
        rd(8'h20, d, di);
        check("R6 level survives w1c", d, 4);
        pin_in = 16'h0000;
        settle(4);
        rd(8'h20, d, di);
        check("R6 level dropped", d, 0);

        // R5 R6 R8 random configurations checked against the model
        for (int b = 0; b < 12; b++) begin
            en_r = $urandom() & PM;
            ty_r = $urandom() & PM;
            po_r = $urandom() & PM;
            mk_r = $urandom() & PM;
            wr(8'h14, en_r);
            wr(8'h18, ty_r);
            wr(8'h1C, po_r);
            wr(8'h24, mk_r);
            wr(8'h20, PM);
            settle(2);
            oldp = 32'(pin_in);
            exp = level_bits(oldp, en_r, ty_r, po_r);
            for (int s = 0; s < 8; s++) begin
                newp = $urandom() & PM;
                pin_in = newp[N-1:0];
                settle(4);
                exp = ((exp & ~ty_r) | edge_hits(oldp, newp, en_r, ty_r, po_r))
                      | level_bits(newp, en_r, ty_r, po_r);
                exp = exp & PM & (ty_r | ~ty_r);
                check("R8 random irq", 32'(irq), 32'(|(exp & en_r & mk_r)));
                rd(8'h20, d, di);
                check("R5 R6 random pend", d, exp);
                oldp = newp;
            end
        end

        finish_run();
    end
endmodule